// File: doc/BRIEF.md
# Row-Burst Memory Request Scheduler

This block sits in front of a multi-bank SDRAM command engine and decides the order in which pending memory requests are handed on. Requests come in one at a time on a valid/ready port. Each request carries a read/write flag, a bank, a row, a column and a tag. Reads and writes wait in two separate 8-entry queues. Every cycle, one granted request leaves on a valid/ready issue port. The issue port carries the original fields and a flag that says whether the request closes a different open row in its bank.

The ordering has four aims. It groups requests that hit the same row of the same bank into back-to-back bursts. It lets reads overtake writes until the write queue grows too full. It appends matching writes to the end of a read burst. It moves to another bank once a burst grows long. A small table inside the block records the row each bank had open last. Command timing, refresh, data movement and address mapping are handled elsewhere.

Top module: `row_burst_sched`

## Requirements
- R1: Each queue holds 8 requests. `req_ready` is low exactly when the queue selected by `req_write` (1 = write) is full. A request is taken when `req_valid` and `req_ready` are both high.
- R2: An issued request shows the same write flag, bank, row, column and tag it arrived with. It leaves its queue when `iss_valid` and `iss_ready` are both high.
- R3: While the current burst is below its cap, a queued request of the chosen kind to the same bank and row as the last issued request is preferred over all others of that kind.
- R4: Apart from bursts, requests within a kind are ranked in this order: first a hit to a bank's recorded open row, then a request to a bank with no recorded row, then any request. Within a rank the earliest arrival wins.
- R5: Outside write-drain mode, an eligible read is issued ahead of any queued write, except when R7 applies.
- R6: Write-drain mode starts on the clock edge after the write queue holds 6 or more entries. It stays on until the queue holds 2 or fewer. While it is on, writes are issued whenever one is queued.
- R7: When the burst was started by a read and no read can continue it, a queued write to the same bank and row is issued next, as long as the cap is not reached.
- R8: A burst counts at most 8 accesses. Once it reaches 8, a request to a different bank is chosen whenever one of the chosen kind is eligible.
- R9: A read is not issued while a write that arrived before it, with the same bank, row and column, is still queued.
- R10: Each issue records its row as the open row of its bank. `iss_conflict` is high when the bank had a different row recorded, and low when the row matched or no row was recorded.
- R11: After reset both queues are empty, no row is recorded, `iss_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Target queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 8 | Row of the request |
| req_col | input | 6 | Column of the request |
| req_tag | input | 4 | Tag returned on issue |
| iss_valid | output | 1 | A request is offered for issue |
| iss_ready | input | 1 | Downstream accepts the offered request |
| iss_write | output | 1 | Kind of the issued request |
| iss_bank | output | 2 | Bank of the issued request |
| iss_row | output | 8 | Row of the issued request |
| iss_col | output | 6 | Column of the issued request |
| iss_tag | output | 4 | Tag of the issued request |
| iss_conflict | output | 1 | Issue replaces a different recorded row |

## Verification
The hardest condition to reach is the burst cap. Reaching it takes nine same-row hits in a row while a request to another bank waits. The queue holds only eight entries, so a preloaded queue cannot reach the cap on its own. The stimulus first opens the row with a single read. It then streams same-row reads so that a new one is pushed in every cycle one is issued, and places a read to another bank partway through the stream. The ordering hazard is reached by parking a write and then a read to the same address while issue is stalled. On release, the read must wait behind the unrelated traffic and the write.

// File: rtl/rbs_pkg.sv
// Package: widths and the request record shared by the scheduler modules.
// Assumes one bank/row/column layout for the whole scheduler.
package rbs_pkg;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int TAG_W  = 4;
    localparam int NBANK  = 1 << BANK_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [TAG_W-1:0]  tag;
    } req_t;

    // True when two requests touch the same memory word.
    function automatic logic same_addr(req_t a, req_t b);
        return (a.bank == b.bank) && (a.row == b.row) && (a.col == b.col);
    endfunction
endpackage

// File: rtl/rbs_queue.sv
// Queue with fixed slots: a new entry takes the lowest free slot, and an age
// matrix keeps the arrival order (older[i][j] set = slot i arrived before j).
// Assumes the caller never pushes when full and pops only valid slots.
module rbs_queue #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_i,
    input  rbs_pkg::req_t                  push_ent_i,
    input  logic                           pop_i,
    input  logic [IDX_W-1:0]               pop_idx_i,
    output rbs_pkg::req_t [DEPTH-1:0]      ents_o,
    output logic [DEPTH-1:0]               vld_o,
    output logic [DEPTH-1:0][DEPTH-1:0]    older_o,
    output logic [IDX_W-1:0]               alloc_idx_o,
    output logic [CNT_W-1:0]               count_o,
    output logic                           full_o
);
    // Lowest free slot receives the next push.
    always_comb begin
        alloc_idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!vld_o[i]) alloc_idx_o = IDX_W'(i);
    end

    assign full_o  = &vld_o;
    assign count_o = CNT_W'($countones(vld_o));

    // Valid bits and age matrix track occupancy and arrival order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= '0;
            older_o <= '0;
        end else begin
            if (pop_i) vld_o[pop_idx_i] <= 1'b0;
            if (push_i) begin
                vld_o[alloc_idx_o] <= 1'b1;
                for (int j = 0; j < DEPTH; j++) begin
                    older_o[alloc_idx_o][j] <= 1'b0;
                    older_o[j][alloc_idx_o] <= vld_o[j] && !(pop_i && pop_idx_i == IDX_W'(j));
                end
            end
        end
    end

    // Payload storage needs no reset.
    always_ff @(posedge clk) begin
        if (push_i) ents_o[alloc_idx_o] <= push_ent_i;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R2
    pop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> vld_o[pop_idx_i]);
endmodule

// File: rtl/rbs_pick.sv
// Ranks the eligible entries of one queue and names the oldest entry in the
// best non-empty rank: burst continuation, open-row hit, closed bank, any.
// When the burst is capped, entries to the burst bank are removed if another
// bank is available. Purely combinational.
module rbs_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  rbs_pkg::req_t [DEPTH-1:0]                          ents_i,
    input  logic [DEPTH-1:0]                                   elig_i,
    input  logic [DEPTH-1:0][DEPTH-1:0]                        older_i,
    input  logic [rbs_pkg::NBANK-1:0]                          open_vld_i,
    input  logic [rbs_pkg::NBANK-1:0][rbs_pkg::ROW_W-1:0]      open_row_i,
    input  logic                                               burst_vld_i,
    input  logic [rbs_pkg::BANK_W-1:0]                         last_bank_i,
    input  logic [rbs_pkg::ROW_W-1:0]                          last_row_i,
    input  logic                                               capped_i,
    output logic                                               any_o,
    output logic                                               cont_o,
    output logic [IDX_W-1:0]                                   idx_o
);
    logic [DEPTH-1:0] other, cand, t_cont, t_hit, t_cls, tier;
    logic             avoid, beaten;

    // Build the rank masks over the candidates.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            other[i] = elig_i[i] && (ents_i[i].bank != last_bank_i);
        avoid = capped_i && (|other);
        cand  = avoid ? other : elig_i;
        for (int i = 0; i < DEPTH; i++) begin
            t_cont[i] = cand[i] && burst_vld_i && !capped_i &&
                        ents_i[i].bank == last_bank_i && ents_i[i].row == last_row_i;
            t_hit[i]  = cand[i] && open_vld_i[ents_i[i].bank] &&
                        open_row_i[ents_i[i].bank] == ents_i[i].row;
            t_cls[i]  = cand[i] && !open_vld_i[ents_i[i].bank];
        end
        if (|t_cont)     tier = t_cont;
        else if (|t_hit) tier = t_hit;
        else if (|t_cls) tier = t_cls;
        else             tier = cand;
        any_o  = |elig_i;
        cont_o = |t_cont;
    end

    // Oldest member of the chosen rank.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++)
                if (tier[j] && older_i[j][i]) beaten = 1'b1;
            if (tier[i] && !beaten) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/row_burst_sched.sv
// Top of the row-burst scheduler. It keeps separate read and write queues,
// records which row each bank had open last, and chooses one request per
// cycle. Writes win in drain mode. Otherwise a matching write is appended at
// the tail of a read burst, and reads go ahead of writes. A read waits for
// older writes to the same address, tracked with per-read dependency masks.
// Assumes downstream takes at most one request per cycle.
module row_burst_sched #(
    parameter int QDEPTH    = 8,
    parameter int WR_HI     = 6,
    parameter int WR_LO     = 2,
    parameter int BURST_MAX = 8,
    localparam int IDX_W = $clog2(QDEPTH),
    localparam int CNT_W = $clog2(QDEPTH + 1),
    localparam int BC_W  = $clog2(BURST_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [rbs_pkg::BANK_W-1:0] req_bank,
    input  logic [rbs_pkg::ROW_W-1:0]  req_row,
    input  logic [rbs_pkg::COL_W-1:0]  req_col,
    input  logic [rbs_pkg::TAG_W-1:0]  req_tag,
    output logic                       iss_valid,
    input  logic                       iss_ready,
    output logic                       iss_write,
    output logic [rbs_pkg::BANK_W-1:0] iss_bank,
    output logic [rbs_pkg::ROW_W-1:0]  iss_row,
    output logic [rbs_pkg::COL_W-1:0]  iss_col,
    output logic [rbs_pkg::TAG_W-1:0]  iss_tag,
    output logic                       iss_conflict
);
    import rbs_pkg::*;

    req_t                           req_ent, sel_ent;
    req_t  [QDEPTH-1:0]             rents, wents;
    logic  [QDEPTH-1:0]             rvld, wvld, rd_elig, wmatch;
    logic  [QDEPTH-1:0][QDEPTH-1:0] rolder, wolder, rdep;
    logic  [IDX_W-1:0]              ralloc, walloc, ridx, widx;
    logic  [CNT_W-1:0]              rcnt, wcnt;
    logic                           rfull, wfull, rd_any, wr_any, rd_cont, wr_cont;
    logic                           acc, rd_push, wr_push, fire, rd_pop, wr_pop, sel_wr, pig;
    logic  [NBANK-1:0]              open_vld;
    logic  [NBANK-1:0][ROW_W-1:0]   open_row;
    logic                           burst_vld, burst_rd, capped, drain, same, dangling;
    logic  [BANK_W-1:0]             last_bank;
    logic  [ROW_W-1:0]              last_row;
    logic  [BC_W-1:0]               bcnt;

    assign req_ent   = '{bank: req_bank, row: req_row, col: req_col, tag: req_tag};
    assign req_ready = req_write ? !wfull : !rfull;
    assign acc       = req_valid && req_ready;
    assign rd_push   = acc && !req_write;
    assign wr_push   = acc && req_write;
    assign capped    = burst_vld && (bcnt >= BC_W'(BURST_MAX));

    rbs_queue #(.DEPTH(QDEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .push_i(rd_push), .push_ent_i(req_ent),
        .pop_i(rd_pop), .pop_idx_i(ridx), .ents_o(rents), .vld_o(rvld),
        .older_o(rolder), .alloc_idx_o(ralloc), .count_o(rcnt), .full_o(rfull));

    rbs_queue #(.DEPTH(QDEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .push_i(wr_push), .push_ent_i(req_ent),
        .pop_i(wr_pop), .pop_idx_i(widx), .ents_o(wents), .vld_o(wvld),
        .older_o(wolder), .alloc_idx_o(walloc), .count_o(wcnt), .full_o(wfull));

    // A read is eligible once it no longer depends on any queued write.
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) rd_elig[i] = rvld[i] && !(|rdep[i]);
    end

    rbs_pick #(.DEPTH(QDEPTH)) u_rpick (
        .ents_i(rents), .elig_i(rd_elig), .older_i(rolder),
        .open_vld_i(open_vld), .open_row_i(open_row), .burst_vld_i(burst_vld),
        .last_bank_i(last_bank), .last_row_i(last_row), .capped_i(capped),
        .any_o(rd_any), .cont_o(rd_cont), .idx_o(ridx));

    rbs_pick #(.DEPTH(QDEPTH)) u_wpick (
        .ents_i(wents), .elig_i(wvld), .older_i(wolder),
        .open_vld_i(open_vld), .open_row_i(open_row), .burst_vld_i(burst_vld),
        .last_bank_i(last_bank), .last_row_i(last_row), .capped_i(capped),
        .any_o(wr_any), .cont_o(wr_cont), .idx_o(widx));

    // Choose read or write: drain first, then tail writes, then reads.
    always_comb begin
        pig = burst_vld && burst_rd && !rd_cont && wr_cont;
        if (drain && wr_any) sel_wr = 1'b1;
        else if (pig)        sel_wr = 1'b1;
        else if (rd_any)     sel_wr = 1'b0;
        else                 sel_wr = 1'b1;
    end

    assign sel_ent      = sel_wr ? wents[widx] : rents[ridx];
    assign iss_valid    = rd_any || wr_any;
    assign iss_write    = sel_wr;
    assign iss_bank     = sel_ent.bank;
    assign iss_row      = sel_ent.row;
    assign iss_col      = sel_ent.col;
    assign iss_tag      = sel_ent.tag;
    assign iss_conflict = open_vld[sel_ent.bank] && (open_row[sel_ent.bank] != sel_ent.row);
    assign fire         = iss_valid && iss_ready;
    assign rd_pop       = fire && !sel_wr;
    assign wr_pop       = fire && sel_wr;
    assign same         = burst_vld && (iss_bank == last_bank) && (iss_row == last_row);

    // Queued writes that an incoming read must wait for.
    always_comb begin
        for (int j = 0; j < QDEPTH; j++)
            wmatch[j] = wvld[j] && same_addr(wents[j], req_ent) &&
                        !(wr_pop && widx == IDX_W'(j));
    end

    // Dependency masks: set when a read arrives, cleared as writes leave.
    always_ff @(posedge clk) begin
        if (!rst_n) rdep <= '0;
        else begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (rd_push && ralloc == IDX_W'(i)) rdep[i] <= wmatch;
                else if (wr_pop)                    rdep[i][widx] <= 1'b0;
            end
        end
    end

    // Burst, open-row and drain-mode state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld  <= '0;
            open_row  <= '0;
            burst_vld <= 1'b0;
            burst_rd  <= 1'b0;
            last_bank <= '0;
            last_row  <= '0;
            bcnt      <= '0;
            drain     <= 1'b0;
        end else begin
            drain <= (wcnt >= CNT_W'(WR_HI)) || (drain && wcnt > CNT_W'(WR_LO));
            if (fire) begin
                open_vld[iss_bank] <= 1'b1;
                open_row[iss_bank] <= iss_row;
                burst_vld <= 1'b1;
                last_bank <= iss_bank;
                last_row  <= iss_row;
                if (same) begin
                    if (!capped) bcnt <= bcnt + 1'b1;
                end else begin
                    bcnt     <= BC_W'(1);
                    burst_rd <= !sel_wr;
                end
            end
        end
    end

    // A live read that still points at an empty write slot.
    always_comb begin
        dangling = 1'b0;
        for (int i = 0; i < QDEPTH; i++)
            if (rvld[i] && |(rdep[i] & ~wvld)) dangling = 1'b1;
    end

    // R9
    dep_live_chk: assert property (@(posedge clk) disable iff (!rst_n) !dangling);
    // R8
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= BC_W'(BURST_MAX));
    // R6
    drain_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt >= CNT_W'(WR_HI)) |=> drain);
    // R1
    rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_push && !rd_pop) |=> (rcnt == CNT_W'($past(rcnt) + 1'b1)));
    // R10
    open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (open_vld[$past(iss_bank)] && open_row[$past(iss_bank)] == $past(iss_row)));
endmodule

// File: tb/row_burst_sched_bench.sv
// Bench: a behavioural reference model with arrival-ordered queues, compared
// against the design on every clock.
module row_burst_sched_bench;
    localparam int QD = 8, HI = 6, LO = 2, BM = 8;

    typedef struct { int b; int r; int c; int t; int seq; } item_t;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, iss_ready = 1'b0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic [3:0] req_tag = '0;
    logic       req_ready, iss_valid, iss_write, iss_conflict;
    logic [1:0] iss_bank;
    logic [7:0] iss_row;
    logic [5:0] iss_col;
    logic [3:0] iss_tag;

    int checks = 0, errors = 0, seqn = 0;
    item_t rq[$], wq[$];
    bit ov[4]; int orow[4];
    bit bvalid, brd, drain; int lbank, lrow, bcnt;

    always #5 clk = ~clk;

    row_burst_sched u_row_burst_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_tag(req_tag), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_write(iss_write), .iss_bank(iss_bank),
        .iss_row(iss_row), .iss_col(iss_col), .iss_tag(iss_tag),
        .iss_conflict(iss_conflict));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        rq.delete(); wq.delete();
        foreach (ov[i]) begin ov[i] = 0; orow[i] = 0; end
        bvalid = 0; brd = 0; drain = 0; lbank = 0; lrow = 0; bcnt = 0;
    endfunction

    function automatic bit blocked(item_t it);
        foreach (wq[j])
            if (wq[j].seq < it.seq && wq[j].b == it.b && wq[j].r == it.r && wq[j].c == it.c) return 1;
        return 0;
    endfunction

    // Rank the entries of one queue in arrival order.
    function automatic void pick_q(input bit isw, output bit any, output bit cont,
                                   output int idx, output bit avd);
        int n; bit el[16]; bit capped, other, ok; item_t it;
        n = isw ? wq.size() : rq.size();
        capped = bvalid && bcnt >= BM;
        any = 0; other = 0; cont = 0; idx = -1;
        for (int i = 0; i < n; i++) begin
            it = isw ? wq[i] : rq[i];
            el[i] = isw ? 1'b1 : !blocked(it);
            any |= el[i];
            if (el[i] && it.b != lbank) other = 1;
        end
        avd = capped && other;
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < n; i++) begin
                it = isw ? wq[i] : rq[i];
                case (t)
                    0: ok = bvalid && !capped && it.b == lbank && it.r == lrow;
                    1: ok = ov[it.b] && orow[it.b] == it.r;
                    2: ok = !ov[it.b];
                    default: ok = 1;
                endcase
                if (idx < 0 && el[i] && (!avd || it.b != lbank) && ok) begin
                    idx = i;
                    if (t == 0) cont = 1;
                end
            end
    endfunction

    // Expected issue choice and the requirement it mainly exercises.
    function automatic void model_pick(output bit v, output bit w, output int qi, output string why);
        bit ra, rc, rav, wa, wc, wav, anyblk; int ri, wi;
        pick_q(0, ra, rc, ri, rav);
        pick_q(1, wa, wc, wi, wav);
        anyblk = 0;
        foreach (rq[i]) if (blocked(rq[i])) anyblk = 1;
        v = ra || wa;
        if (drain && wa)                      begin w = 1; why = "R6"; end
        else if (bvalid && brd && !rc && wc)  begin w = 1; why = "R7"; end
        else if (ra)                          begin w = 0; why = "R4"; end
        else                                  begin w = 1; why = "R4"; end
        qi = w ? wi : ri;
        if (why == "R4") begin
            if ((w ? wav : rav))                     why = "R8";
            else if ((w ? wc : rc))                  why = "R3";
            else if (!w && anyblk)                   why = "R9";
            else if (!w && wq.size() > 0)            why = "R5";
        end
    endfunction

    // Compare on every cycle, then advance the model to the next edge.
    always begin
        bit ev, ew, er, dn; int qi; string why; item_t it, ni;
        logic [20:0] act, exp;
        @(negedge clk); #1;
        if (!rst_n) model_reset();
        else begin
            model_pick(ev, ew, qi, why);
            er = req_write ? (wq.size() < QD) : (rq.size() < QD);
            chk(req_ready === er, "R1 req_ready", req_ready, er);
            chk(iss_valid === ev, {why, " iss_valid"}, iss_valid, ev);
            if (ev) begin
                it = ew ? wq[qi] : rq[qi];
                act = {iss_write, iss_bank, iss_row, iss_col, iss_tag};
                exp = {ew, 2'(it.b), 8'(it.r), 6'(it.c), 4'(it.t)};
                chk(act === exp, {why, "/R2 issued fields"}, act, exp);
                chk(iss_conflict === (ov[it.b] && orow[it.b] != it.r), "R10 conflict",
                    iss_conflict, (ov[it.b] && orow[it.b] != it.r));
            end
            dn = (wq.size() >= HI) || (drain && wq.size() > LO);
            if (ev && iss_ready) begin
                if (bvalid && it.b == lbank && it.r == lrow) begin
                    if (bcnt < BM) bcnt++;
                end else begin
                    bcnt = 1; brd = !ew;
                end
                bvalid = 1; lbank = it.b; lrow = it.r;
                ov[it.b] = 1; orow[it.b] = it.r;
                if (ew) wq.delete(qi); else rq.delete(qi);
            end
            if (req_valid && er) begin
                ni = '{b: int'(req_bank), r: int'(req_row), c: int'(req_col), t: int'(req_tag), seq: seqn++};
                if (req_write) wq.push_back(ni); else rq.push_back(ni);
            end
            drain = dn;
        end
    end

    task automatic put(input bit w, input int b, input int r, input int c, input int t);
        req_valid = 1; req_write = w;
        req_bank = 2'(b); req_row = 8'(r); req_col = 6'(c); req_tag = 4'(t);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R11 reset state
        chk(iss_valid === 1'b0, "R11 iss_valid after reset", iss_valid, 0);
        chk(req_ready === 1'b1, "R11 req_ready after reset", req_ready, 1);
        @(negedge clk);
        // R1: fill the read queue past its depth with issue stalled
        iss_ready = 0;
        for (int i = 0; i < 9; i++) put(0, i % 4, i, i, i);
        iss_ready = 1; idle(20);
        // R9: read behind an older write to the same address
        iss_ready = 0;
        put(1, 3, 7, 9, 1); put(0, 3, 7, 9, 2); put(0, 0, 1, 0, 3); put(0, 3, 7, 9, 4);
        iss_ready = 1; idle(12);
        // R6: write queue crosses the drain threshold
        iss_ready = 0;
        for (int i = 0; i < 7; i++) put(1, i % 4, 10 + i, i, i);
        put(0, 1, 2, 3, 8); put(0, 2, 2, 3, 9);
        iss_ready = 1; idle(30);
        // R7: matching writes at the tail of a read burst
        iss_ready = 0;
        put(0, 1, 5, 0, 1); put(0, 1, 5, 1, 2); put(0, 1, 5, 2, 3);
        put(1, 1, 5, 4, 4); put(1, 1, 5, 5, 5); put(1, 2, 0, 0, 6); put(0, 2, 3, 0, 7);
        iss_ready = 1; idle(20);
        // R8: open bank0 row1, then stream same-row reads with another bank waiting
        put(0, 0, 1, 0, 0); idle(3);
        for (int i = 0; i < 14; i++) begin
            if (i == 3) put(0, 2, 9, 1, 15);
            else put(0, 0, 1, i, i);
        end
        idle(20);
        // Mixed traffic with random back-pressure
        for (int i = 0; i < 3000; i++) begin
            iss_ready = ($urandom_range(0, 3) != 0);
            req_valid = ($urandom_range(0, 2) != 0);
            req_write = $urandom_range(0, 1);
            req_bank = 2'($urandom_range(0, 3));
            req_row = 8'($urandom_range(0, 2));
            req_col = 6'($urandom_range(0, 3));
            req_tag = 4'($urandom_range(0, 15));
            @(negedge clk);
        end
        iss_ready = 1; idle(60);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule